// File: doc/BRIEF.md
# Bus-Loaded Memory Address Counter

This block drives the address lines of an external byte-wide memory, so that the host controller does not need one pin per address bit. The host writes the address into the counter over the memory's own 8-bit data bus. Each write carries a byte index that picks which address byte is replaced, so one byte can be changed without rewriting the others. After the address is loaded, one increment strobe per access steps the address forward.

There are two ways to step the address. In block mode, only the low `BLOCK_LOG2` bits count, and they wrap inside a power-of-two block. In paging mode, the counter supplies only the bits at and above `PAGE_LOG2`, and the host drives the low bits directly. In that mode each increment moves to the next page. A clear strobe returns the counter to zero. All strobes are sampled on the rising clock edge, and the address changes right after that edge.

Top module: `bus_addr_counter`

## Requirements
- R1: After `rstN` is released with no strobes active, `addrOut` reads 0 in block mode.
- R2: When `loadStb` is high on an edge, the address byte picked by `byteSel` takes `busData`. Index 0 is bits 7:0, index 1 is bits 15:8 and index 2 is bits 23:16. The other bytes keep their values.
- R3: A load with `byteSel` = 3 changes no part of the address.
- R4: In block mode (`pageMode` = 0), an increment adds one modulo 2^BLOCK_LOG2 to the low BLOCK_LOG2 bits, and leaves every bit above them unchanged. With the default of 8, the low byte 0xFF becomes 0x00.
- R5: In paging mode (`pageMode` = 1), `addrOut` is the counter's bits 23:PAGE_LOG2 followed by `hostLow`. An increment adds one to the page bits, wrapping from all ones to zero. The stored low bits are kept and reappear when block mode returns.
- R6: `clearStb` sets the whole counter to zero. It wins over a load or an increment in the same cycle.
- R7: When `loadStb` and `incStb` are both high on one edge, only the load takes effect.
- R8: On an edge with no strobe active, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busData | input | 8 | Shared memory data bus, carries address bytes |
| loadStb | input | 1 | Load one address byte from busData |
| byteSel | input | 2 | Index of the address byte to load |
| incStb | input | 1 | Advance the address (or the page) by one |
| clearStb | input | 1 | Synchronous clear of the counter |
| pageMode | input | 1 | 1 = paging mode, 0 = block mode |
| hostLow | input | PAGE_LOG2 (8) | Low address bits driven by the host in paging mode |
| addrOut | output | 24 | Address lines to the memory |

## Verification
The bench steps the low byte across 0xFF so a carry that leaks into bit 8 would show up as a wrong middle byte. It also steps the page bits from all ones, where a page counter that did not wrap would corrupt the address. Loads to one byte check that the neighbouring bytes survive, and a load with index 3 catches a decoder that aliases it onto a real byte. Strobes that collide in one cycle (load with increment, clear with load, clear with increment) expose a wrong priority order, which would show up as an address one higher or not cleared. Switching back out of paging mode checks that the low bits stored earlier were kept rather than overwritten by the host's bits.

// File: rtl/bus_addr_counter_pkg.sv
package bus_addr_counter_pkg;
  typedef struct packed {
    logic clr;
    logic load;
    logic incBlock;
    logic incPage;
  } ctrlStrobes_t;
endpackage

// File: rtl/bus_addr_counter_ctrl.sv
module bus_addr_counter_ctrl
  import bus_addr_counter_pkg::*;
(
  input  logic         clearStb,
  input  logic         loadStb,
  input  logic         incStb,
  input  logic         pageMode,
  output ctrlStrobes_t strobes
);
  // Priority: clear, then load, then increment
  always_comb begin
    strobes          = '0;
    strobes.clr      = clearStb;
    strobes.load     = !clearStb && loadStb;
    strobes.incBlock = !clearStb && !loadStb && incStb && !pageMode;
    strobes.incPage  = !clearStb && !loadStb && incStb && pageMode;
  end
endmodule

// File: rtl/bus_addr_counter_dp.sv
module bus_addr_counter_dp
  import bus_addr_counter_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BLOCK_LOG2 = 8,
  parameter int PAGE_LOG2  = 8,
  localparam int NUM_BYTES = ADDR_W / 8,
  localparam int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES + 1) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [7:0]           busData,
  input  logic [SEL_W-1:0]     byteSel,
  input  logic                 pageMode,
  input  logic [PAGE_LOG2-1:0] hostLow,
  output logic [ADDR_W-1:0]    countQ,
  output logic [ADDR_W-1:0]    addrOut
);
  localparam logic [ADDR_W-1:0] BLOCK_MASK = ADDR_W'((64'(1) << BLOCK_LOG2) - 64'(1));
  localparam logic [ADDR_W-1:0] PAGE_STEP  = ADDR_W'(64'(1) << PAGE_LOG2);

  logic [ADDR_W-1:0] blockNext;
  logic [ADDR_W-1:0] pageNext;
  logic [ADDR_W-1:0] loadNext;

  assign blockNext = (countQ & ~BLOCK_MASK) | ((countQ + 1'b1) & BLOCK_MASK);
  assign pageNext  = countQ + PAGE_STEP;

  // One byte lane per address byte; only the addressed lane takes the bus
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    always_comb begin
      if (byteSel == SEL_W'(i)) loadNext[i*8 +: 8] = busData;
      else                      loadNext[i*8 +: 8] = countQ[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 countQ <= '0;
    else if (strobes.clr)      countQ <= '0;
    else if (strobes.load)     countQ <= loadNext;
    else if (strobes.incBlock) countQ <= blockNext;
    else if (strobes.incPage)  countQ <= pageNext;
  end

  always_comb begin
    if (pageMode) addrOut = {countQ[ADDR_W-1:PAGE_LOG2], hostLow};
    else          addrOut = countQ;
  end
endmodule

// File: rtl/bus_addr_counter.sv
module bus_addr_counter
  import bus_addr_counter_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BLOCK_LOG2 = 8,
  parameter int PAGE_LOG2  = 8,
  localparam int NUM_BYTES = ADDR_W / 8,
  localparam int SEL_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES + 1) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           busData,
  input  logic                 loadStb,
  input  logic [SEL_W-1:0]     byteSel,
  input  logic                 incStb,
  input  logic                 clearStb,
  input  logic                 pageMode,
  input  logic [PAGE_LOG2-1:0] hostLow,
  output logic [ADDR_W-1:0]    addrOut
);
  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] countQ;

  bus_addr_counter_ctrl u_ctrl (
    .clearStb (clearStb),
    .loadStb  (loadStb),
    .incStb   (incStb),
    .pageMode (pageMode),
    .strobes  (strobes)
  );

  bus_addr_counter_dp #(
    .ADDR_W     (ADDR_W),
    .BLOCK_LOG2 (BLOCK_LOG2),
    .PAGE_LOG2  (PAGE_LOG2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busData  (busData),
    .byteSel  (byteSel),
    .pageMode (pageMode),
    .hostLow  (hostLow),
    .countQ   (countQ),
    .addrOut  (addrOut)
  );
endmodule

// File: rtl/bus_addr_counter_chk.sv
module bus_addr_counter_chk #(
  parameter int ADDR_W     = 24,
  parameter int BLOCK_LOG2 = 8,
  parameter int PAGE_LOG2  = 8,
  parameter int SEL_W      = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        busData,
  input logic              loadStb,
  input logic [SEL_W-1:0]  byteSel,
  input logic              incStb,
  input logic              clearStb,
  input logic              pageMode,
  input logic [ADDR_W-1:0] countQ
);
  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> (countQ == '0));

  // R2
  load_low_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clearStb && loadStb && byteSel == '0) |=> (countQ[7:0] == $past(busData)));

  // R7
  load_beats_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clearStb && loadStb && incStb && byteSel == '0)
      |=> (countQ[ADDR_W-1:8] == $past(countQ[ADDR_W-1:8])));

  // R4
  block_upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clearStb && !loadStb && incStb && !pageMode)
      |=> (countQ[ADDR_W-1:BLOCK_LOG2] == $past(countQ[ADDR_W-1:BLOCK_LOG2])));

  // R5
  page_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clearStb && !loadStb && incStb && pageMode)
      |=> (countQ[ADDR_W-1:PAGE_LOG2] == $past(countQ[ADDR_W-1:PAGE_LOG2]) + 1'b1)
          && (countQ[PAGE_LOG2-1:0] == $past(countQ[PAGE_LOG2-1:0])));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clearStb && !loadStb && !incStb) |=> $stable(countQ));
endmodule

bind bus_addr_counter bus_addr_counter_chk #(
  .ADDR_W     (ADDR_W),
  .BLOCK_LOG2 (BLOCK_LOG2),
  .PAGE_LOG2  (PAGE_LOG2),
  .SEL_W      (SEL_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busData  (busData),
  .loadStb  (loadStb),
  .byteSel  (byteSel),
  .incStb   (incStb),
  .clearStb (clearStb),
  .pageMode (pageMode),
  .countQ   (countQ)
);

// File: tb/bus_addr_counter_bench.sv
module bus_addr_counter_bench;
  localparam int AW = 24;
  localparam int BL = 8;
  localparam int PL = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busData = '0;
  logic          loadStb = 1'b0;
  logic [1:0]    byteSel = '0;
  logic          incStb = 1'b0;
  logic          clearStb = 1'b0;
  logic          pageMode = 1'b0;
  logic [PL-1:0] hostLow = '0;
  logic [AW-1:0] addrOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [AW-1:0] expQ[$];
  string         tagQ[$];
  logic [AW-1:0] model = '0;

  always #5 clk = ~clk;

  bus_addr_counter u_bus_addr_counter (
    .clk(clk), .rstN(rstN), .busData(busData), .loadStb(loadStb),
    .byteSel(byteSel), .incStb(incStb), .clearStb(clearStb),
    .pageMode(pageMode), .hostLow(hostLow), .addrOut(addrOut)
  );

  // Apply one cycle of stimulus and push the expected address after the edge
  task automatic step(input bit clr, input bit ld, input bit inc, input logic [1:0] sel,
                      input logic [7:0] data, input bit pm, input logic [PL-1:0] low,
                      input string tag);
    logic [AW-1:0] upper;
    @(negedge clk);
    clearStb = clr; loadStb = ld; incStb = inc; byteSel = sel;
    busData = data; pageMode = pm; hostLow = low;
    if (clr) model = '0;
    else if (ld) begin
      if (sel != 2'd3) model[sel*8 +: 8] = data;
    end else if (inc) begin
      if (pm) begin
        upper = (model >> PL) + 1;
        model = (upper << PL) | (model & AW'((1 << PL) - 1));
      end else begin
        model = ((model >> BL) << BL) | AW'((model + 1) % (1 << BL));
      end
    end
    if (pm) expQ.push_back(((model >> PL) << PL) | AW'(low));
    else    expQ.push_back(model);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare each expected item shortly after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [AW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (addrOut !== e) begin
          errors++;
          $display("FAIL %s: addrOut=%06h expected=%06h", t, addrOut, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0,0,0,0,8'h00,0,8'h00,"R1 reset value");
    step(0,1,0,0,8'h12,0,8'h00,"R2 load byte0");
    step(0,1,0,1,8'h34,0,8'h00,"R2 load byte1");
    step(0,1,0,2,8'h56,0,8'h00,"R2 load byte2");
    step(0,1,0,3,8'hFF,0,8'h00,"R3 index 3 ignored");
    step(0,1,0,1,8'hAB,0,8'h00,"R2 single byte update");
    step(0,0,0,0,8'h99,0,8'h00,"R8 idle hold");
    step(0,0,1,0,8'h00,0,8'h00,"R4 block inc");
    step(0,1,0,0,8'hFE,0,8'h00,"R2 load near wrap");
    step(0,0,1,0,8'h00,0,8'h00,"R4 inc to FF");
    step(0,0,1,0,8'h00,0,8'h00,"R4 block wrap keeps upper");
    step(0,1,1,0,8'h40,0,8'h00,"R7 load beats inc");
    step(1,1,0,2,8'h77,0,8'h00,"R6 clear beats load");
    step(0,1,0,2,8'h11,0,8'h00,"R2 reload byte2");
    step(1,0,1,0,8'h00,0,8'h00,"R6 clear beats inc");
    step(0,1,0,1,8'hFF,0,8'h00,"R2 page setup byte1");
    step(0,1,0,2,8'hFF,0,8'h00,"R2 page setup byte2");
    step(0,1,0,0,8'h77,0,8'h00,"R2 page setup byte0");
    step(0,0,0,0,8'h00,1,8'h3C,"R5 page output");
    step(0,0,1,0,8'h00,1,8'h3C,"R5 page wrap");
    step(0,0,0,0,8'h00,1,8'hC5,"R5 host low follows");
    step(0,0,1,0,8'h00,1,8'hC5,"R5 page inc");
    step(0,0,0,0,8'h00,0,8'h00,"R5 stored low kept");
    for (int i = 0; i < 300; i++)
      step(0,0,1,0,8'h00,0,8'h00,"R4 long block run");
    for (int i = 0; i < 20; i++)
      step(0,0,1,0,8'h00,1,PL'(i*13),"R5 long page run");
    step(0,0,0,0,8'h00,0,8'h00,"R8 final hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule